// File: doc/BRIEF.md
# Load Data Aligner and Extender

This block sits between an execution pipeline and a 32-bit, little-endian data memory port. Each request carries an operation code, a base address, a signed immediate offset, a source value (for stores) and a destination register tag (for loads). The block adds the offset to the base to form the effective address. It decodes the access size and the kind of extension from the operation code, and it checks that the address is aligned to that size.

For a store, it issues a write in the same cycle. The write carries a word-aligned address, per-byte write enables and the source data copied into every lane the access could use. For a load, it issues a read in the same cycle. It keeps the low address bits and the size and extension choice in a register. One cycle later it takes the addressed byte, halfword or word out of the returned word, extends it and presents it as a register writeback. A misaligned access issues no memory request and produces no writeback. It raises a trap with a cause code in the cycle of the request. Operation codes the block does not recognise are ignored.

Top module: `lsa_top`

## Requirements
- R1: The effective address is `req_base` plus `req_offset` sign-extended to the address width. `mem_addr` carries this address with bits 1:0 forced to zero.
- R2: Load code 0 reads a byte and sign-extends it. Load code 4 reads a byte and zero-extends it. The byte comes from lane `ea[1:0]` of the read word, where lane k is bits 8k+7:8k.
- R3: Load code 1 reads a halfword and sign-extends it. Load code 5 reads a halfword and zero-extends it. The halfword is bits 15:0 of the read word when `ea[1]`=0 and bits 31:16 when `ea[1]`=1.
- R4: Load code 2 returns the full read word unchanged.
- R5: A load request asserts `mem_req` with `mem_we`=0. Exactly one cycle later, `wb_valid` is 1 with the request's tag on `wb_dest` and the extracted value on `wb_data`. The extraction uses the address bits and operation code held from the request cycle, even when new requests follow back to back.
- R6: Store code 32 writes one byte. `mem_wdata` is the source's low byte copied into all four lanes, and `mem_be` has only bit `ea[1:0]` set.
- R7: Store code 33 writes a halfword. `mem_wdata` is the source's low halfword in both halves. `mem_be` is 4'b0011 when `ea[1]`=0 and 4'b1100 when `ea[1]`=1.
- R8: Store code 34 writes the source word with `mem_be`=4'b1111.
- R9: A halfword access with `ea[0]`=1 is misaligned, and so is a word access with `ea[1:0]`≠0. A misaligned access drives `trap_valid`=1 and `trap_cause`=4'd2 in the request cycle. Aligned accesses never trap.
- R10: A misaligned access asserts no `mem_req` and produces no `wb_valid` in the following cycle.
- R11: A request with any operation code other than 0, 1, 2, 4, 5, 32, 33 or 34 asserts no `mem_req`, no trap and no writeback.
- R12: While `rst` is high, and in the first cycle after it, `wb_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_op | input | 6 | Operation code |
| req_base | input | ADDR_W | Base address register value |
| req_offset | input | OFF_W | Signed immediate offset |
| req_src | input | 32 | Store source value |
| req_dest | input | TAG_W | Destination register tag for loads |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Memory write (1) or read (0) |
| mem_addr | output | ADDR_W | Word-aligned memory address |
| mem_be | output | 4 | Per-byte write enables |
| mem_wdata | output | 32 | Lane-replicated write data |
| mem_rdata | input | 32 | Read data, valid one cycle after a read request |
| trap_valid | output | 1 | Misaligned access trap |
| trap_cause | output | 4 | Trap cause code |
| wb_valid | output | 1 | Load writeback valid |
| wb_dest | output | TAG_W | Writeback register tag |
| wb_data | output | 32 | Extended load result |

## Verification
The assertions watch invariants on every cycle. A trapping request never reaches memory or writeback. A byte store enables exactly one lane and a halfword store one aligned pair. A zero-extending byte load never shows upper bits. Every accepted load is followed by a writeback, and reset keeps the writeback quiet. Only the bench scenarios can show that the chosen lane and the extension are the right ones for each address offset. The same holds for a negative offset forming the address, for back-to-back loads each using their own held address bits, and for unknown codes leaving memory untouched. The bench shows these by comparing against its own shadow memory.

// File: rtl/lsa_pkg.sv
package lsa_pkg;

    localparam int DATA_W  = 32;
    localparam int LANES   = DATA_W / 8;
    localparam int OP_W    = 6;
    localparam int CAUSE_W = 4;

    localparam logic [OP_W-1:0] OP_LOAD_SB  = 6'd0;
    localparam logic [OP_W-1:0] OP_LOAD_SH  = 6'd1;
    localparam logic [OP_W-1:0] OP_LOAD_W   = 6'd2;
    localparam logic [OP_W-1:0] OP_LOAD_UB  = 6'd4;
    localparam logic [OP_W-1:0] OP_LOAD_UH  = 6'd5;
    localparam logic [OP_W-1:0] OP_STORE_B  = 6'd32;
    localparam logic [OP_W-1:0] OP_STORE_H  = 6'd33;
    localparam logic [OP_W-1:0] OP_STORE_W  = 6'd34;

    localparam logic [CAUSE_W-1:0] CAUSE_MISALIGN = 4'd2;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2
    } acc_size_e;

    typedef struct packed {
        logic      known;
        logic      is_store;
        logic      sign_ext;
        acc_size_e size;
    } acc_ctl_t;

    function automatic acc_ctl_t decode_op(input logic [OP_W-1:0] op);
        acc_ctl_t c;
        c = '{known: 1'b1, is_store: 1'b0, sign_ext: 1'b0, size: SZ_WORD};
        case (op)
            OP_LOAD_SB: begin c.size = SZ_BYTE; c.sign_ext = 1'b1; end
            OP_LOAD_SH: begin c.size = SZ_HALF; c.sign_ext = 1'b1; end
            OP_LOAD_W:  c.size = SZ_WORD;
            OP_LOAD_UB: c.size = SZ_BYTE;
            OP_LOAD_UH: c.size = SZ_HALF;
            OP_STORE_B: begin c.size = SZ_BYTE; c.is_store = 1'b1; end
            OP_STORE_H: begin c.size = SZ_HALF; c.is_store = 1'b1; end
            OP_STORE_W: begin c.size = SZ_WORD; c.is_store = 1'b1; end
            default:    c.known = 1'b0;
        endcase
        return c;
    endfunction

    function automatic logic misaligned(input acc_size_e sz, input logic [1:0] lo);
        case (sz)
            SZ_HALF: return lo[0];
            SZ_WORD: return |lo;
            default: return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/lsa_agu.sv
module lsa_agu #(
    parameter int ADDR_W = 32,
    parameter int OFF_W  = 16
) (
    input  logic [ADDR_W-1:0] base,
    input  logic [OFF_W-1:0]  offset,
    output logic [ADDR_W-1:0] ea
);
    localparam int EXT_W = ADDR_W - OFF_W;

    logic [ADDR_W-1:0] off_ext;

    generate
        if (EXT_W > 0) begin : g_ext
            assign off_ext = {{EXT_W{offset[OFF_W-1]}}, offset};
        end else begin : g_trunc
            assign off_ext = offset[ADDR_W-1:0];
        end
    endgenerate

    assign ea = base + off_ext;
endmodule

// File: rtl/lsa_store_fmt.sv
module lsa_store_fmt
    import lsa_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 active,
    input  acc_size_e            size,
    input  logic [1:0]           lo,
    input  logic [DATA_W-1:0]    src,
    output logic [LANES-1:0]     be,
    output logic [DATA_W-1:0]    wdata
);
    generate
        for (genvar g = 0; g < LANES; g++) begin : g_lane
            localparam logic [1:0] LANE = g[1:0];
            always_comb begin
                case (size)
                    SZ_BYTE: be[g] = (lo == LANE);
                    SZ_HALF: be[g] = (lo[1] == LANE[1]);
                    default: be[g] = 1'b1;
                endcase
            end
        end
    endgenerate

    always_comb begin
        case (size)
            SZ_BYTE: wdata = {LANES{src[7:0]}};
            SZ_HALF: wdata = {(LANES/2){src[15:0]}};
            default: wdata = src;
        endcase
    end

    assert_byte_one_lane_R6: assert property (@(posedge clk) disable iff (rst)
        (active && size == SZ_BYTE) |-> ($countones(be) == 1));

    assert_half_pair_R7: assert property (@(posedge clk) disable iff (rst)
        (active && size == SZ_HALF) |-> (be == 4'b0011 || be == 4'b1100));
endmodule

// File: rtl/lsa_load_fmt.sv
module lsa_load_fmt
    import lsa_pkg::*;
#(
    parameter int TAG_W = 6
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 capture,
    input  acc_size_e            size,
    input  logic                 sign_ext,
    input  logic [1:0]           lo,
    input  logic [TAG_W-1:0]     dest,
    input  logic [DATA_W-1:0]    rdata,
    output logic                 wb_valid,
    output logic [TAG_W-1:0]     wb_dest,
    output logic [DATA_W-1:0]    wb_data
);
    typedef struct packed {
        acc_size_e  size;
        logic       sign_ext;
        logic [1:0] lo;
    } held_t;

    held_t             held;
    logic [DATA_W-1:0] shifted;

    always_ff @(posedge clk) begin
        if (rst) begin
            wb_valid <= 1'b0;
            wb_dest  <= '0;
            held     <= '{size: SZ_WORD, sign_ext: 1'b0, lo: 2'b00};
        end else begin
            wb_valid <= capture;
            if (capture) begin
                wb_dest  <= dest;
                held     <= '{size: size, sign_ext: sign_ext, lo: lo};
            end
        end
    end

    assign shifted = rdata >> {held.lo, 3'b000};

    always_comb begin
        case (held.size)
            SZ_BYTE: wb_data = {{(DATA_W-8){held.sign_ext & shifted[7]}}, shifted[7:0]};
            SZ_HALF: wb_data = {{(DATA_W-16){held.sign_ext & shifted[15]}}, shifted[15:0]};
            default: wb_data = rdata;
        endcase
    end

    assert_zero_ext_byte_R2: assert property (@(posedge clk) disable iff (rst)
        (wb_valid && held.size == SZ_BYTE && !held.sign_ext) |-> (wb_data[DATA_W-1:8] == '0));

    assert_zero_ext_half_R3: assert property (@(posedge clk) disable iff (rst)
        (wb_valid && held.size == SZ_HALF && !held.sign_ext) |-> (wb_data[DATA_W-1:16] == '0));
endmodule

// File: rtl/lsa_top.sv
module lsa_top
    import lsa_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int OFF_W  = 16,
    parameter int TAG_W  = 6
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 req_valid,
    input  logic [OP_W-1:0]      req_op,
    input  logic [ADDR_W-1:0]    req_base,
    input  logic [OFF_W-1:0]     req_offset,
    input  logic [DATA_W-1:0]    req_src,
    input  logic [TAG_W-1:0]     req_dest,
    output logic                 mem_req,
    output logic                 mem_we,
    output logic [ADDR_W-1:0]    mem_addr,
    output logic [LANES-1:0]     mem_be,
    output logic [DATA_W-1:0]    mem_wdata,
    input  logic [DATA_W-1:0]    mem_rdata,
    output logic                 trap_valid,
    output logic [CAUSE_W-1:0]   trap_cause,
    output logic                 wb_valid,
    output logic [TAG_W-1:0]     wb_dest,
    output logic [DATA_W-1:0]    wb_data
);
    acc_ctl_t          ctl;
    logic [ADDR_W-1:0] ea;
    logic              live;
    logic              bad_align;
    logic              go;
    logic              load_go;
    logic              store_go;

    lsa_agu #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_agu (
        .base   (req_base),
        .offset (req_offset),
        .ea     (ea)
    );

    assign ctl       = decode_op(req_op);
    assign live      = req_valid && ctl.known;
    assign bad_align = misaligned(ctl.size, ea[1:0]);
    assign go        = live && !bad_align;
    assign load_go   = go && !ctl.is_store;
    assign store_go  = go && ctl.is_store;

    assign trap_valid = live && bad_align;
    assign trap_cause = trap_valid ? CAUSE_MISALIGN : '0;

    assign mem_req  = go;
    assign mem_we   = store_go;
    assign mem_addr = {ea[ADDR_W-1:2], 2'b00};

    lsa_store_fmt u_store (
        .clk    (clk),
        .rst    (rst),
        .active (store_go),
        .size   (ctl.size),
        .lo     (ea[1:0]),
        .src    (req_src),
        .be     (mem_be),
        .wdata  (mem_wdata)
    );

    lsa_load_fmt #(.TAG_W(TAG_W)) u_load (
        .clk      (clk),
        .rst      (rst),
        .capture  (load_go),
        .size     (ctl.size),
        .sign_ext (ctl.sign_ext),
        .lo       (ea[1:0]),
        .dest     (req_dest),
        .rdata    (mem_rdata),
        .wb_valid (wb_valid),
        .wb_dest  (wb_dest),
        .wb_data  (wb_data)
    );

    assert_trap_no_mem_R10: assert property (@(posedge clk) disable iff (rst)
        trap_valid |-> !mem_req);

    assert_trap_no_wb_R10: assert property (@(posedge clk) disable iff (rst)
        trap_valid |=> !wb_valid);

    assert_read_then_wb_R5: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_we) |=> wb_valid);

    assert_trap_cause_R9: assert property (@(posedge clk) disable iff (rst)
        trap_valid |-> (trap_cause == CAUSE_MISALIGN));

    assert_reset_quiet_R12: assert property (@(posedge clk)
        rst |=> !wb_valid);
endmodule

// File: tb/sim_lsa_top.sv
module sim_lsa_top;
    import lsa_pkg::*;

    localparam int ADDR_W = 32;
    localparam int OFF_W  = 16;
    localparam int TAG_W  = 6;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              req_valid = 1'b0;
    logic [5:0]        req_op = '0;
    logic [31:0]       req_base = '0;
    logic [15:0]       req_offset = '0;
    logic [31:0]       req_src = '0;
    logic [5:0]        req_dest = '0;
    logic              mem_req, mem_we;
    logic [31:0]       mem_addr;
    logic [3:0]        mem_be;
    logic [31:0]       mem_wdata;
    logic [31:0]       mem_rdata = '0;
    logic              trap_valid;
    logic [3:0]        trap_cause;
    logic              wb_valid;
    logic [5:0]        wb_dest;
    logic [31:0]       wb_data;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [31:0] ram    [16];
    logic [31:0] shadow [16];
    logic [37:0] exp_q  [$];

    always #10 clk = ~clk;

    lsa_top #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .TAG_W(TAG_W)) u0 (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op),
        .req_base(req_base), .req_offset(req_offset), .req_src(req_src),
        .req_dest(req_dest), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_be(mem_be), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .trap_valid(trap_valid), .trap_cause(trap_cause),
        .wb_valid(wb_valid), .wb_dest(wb_dest), .wb_data(wb_data)
    );

    always @(posedge clk) begin
        if (mem_req) begin
            if (mem_we) begin
                for (int k = 0; k < 4; k++)
                    if (mem_be[k]) ram[mem_addr[5:2]][8*k +: 8] <= mem_wdata[8*k +: 8];
            end else begin
                mem_rdata <= ram[mem_addr[5:2]];
            end
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // monitor: pops expected writebacks (R5, R2, R3, R4)
    always @(negedge clk) begin
        if (!rst && wb_valid) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R10/R11", "unexpected wb_valid", {26'd0, wb_dest}, 32'd0);
            end else begin
                logic [37:0] e;
                e = exp_q.pop_front();
                chk(wb_dest == e[37:32], "R5", "wb_dest", {26'd0, wb_dest}, {26'd0, e[37:32]});
                chk(wb_data == e[31:0], "R2/R3/R4", "wb_data", wb_data, e[31:0]);
            end
        end
    end

    // driver: one request per cycle, combinational outputs checked mid-cycle
    task automatic do_op(input logic [5:0] op, input logic [31:0] base,
                         input logic [15:0] off, input logic [31:0] src,
                         input logic [5:0] dest, input string req);
        logic [31:0] ea, w, exp_wd, ld;
        logic [3:0]  exp_be;
        logic [1:0]  lo;
        int          sz;
        bit          known, store, sgn, bad;
        @(negedge clk);
        req_valid = 1'b1; req_op = op; req_base = base; req_offset = off;
        req_src = src; req_dest = dest;
        ea = base + {{16{off[15]}}, off};
        lo = ea[1:0];
        known = 1'b1; store = 1'b0; sgn = 1'b0; sz = 4;
        case (op)
            6'd0:  begin sz = 1; sgn = 1'b1; end
            6'd1:  begin sz = 2; sgn = 1'b1; end
            6'd2:  sz = 4;
            6'd4:  sz = 1;
            6'd5:  sz = 2;
            6'd32: begin sz = 1; store = 1'b1; end
            6'd33: begin sz = 2; store = 1'b1; end
            6'd34: begin sz = 4; store = 1'b1; end
            default: known = 1'b0;
        endcase
        bad = known && ((sz == 2 && lo[0]) || (sz == 4 && lo != 2'b00));
        #1;
        chk(trap_valid == bad, bad ? "R9" : "R11", "trap_valid", {31'd0, trap_valid}, {31'd0, bad});
        if (bad) chk(trap_cause == 4'd2, "R9", "trap_cause", {28'd0, trap_cause}, 32'd2);
        chk(mem_req == (known && !bad), bad ? "R10" : "R11", "mem_req",
            {31'd0, mem_req}, {31'd0, known && !bad});
        if (known && !bad) begin
            chk(mem_addr == {ea[31:2], 2'b00}, "R1", "mem_addr", mem_addr, {ea[31:2], 2'b00});
            chk(mem_we == store, store ? "R6" : "R5", "mem_we", {31'd0, mem_we}, {31'd0, store});
            if (store) begin
                if (sz == 1) begin
                    exp_be = 4'b0001 << lo; exp_wd = {4{src[7:0]}};
                end else if (sz == 2) begin
                    exp_be = lo[1] ? 4'b1100 : 4'b0011; exp_wd = {2{src[15:0]}};
                end else begin
                    exp_be = 4'b1111; exp_wd = src;
                end
                chk(mem_be == exp_be, req, "mem_be", {28'd0, mem_be}, {28'd0, exp_be});
                chk(mem_wdata == exp_wd, req, "mem_wdata", mem_wdata, exp_wd);
                for (int k = 0; k < 4; k++)
                    if (exp_be[k]) shadow[ea[5:2]][8*k +: 8] = exp_wd[8*k +: 8];
            end else begin
                w = shadow[ea[5:2]];
                if (sz == 1) begin
                    ld = {24'd0, w[8*lo +: 8]};
                    if (sgn && ld[7]) ld[31:8] = '1;
                end else if (sz == 2) begin
                    ld = {16'd0, w[16*lo[1] +: 16]};
                    if (sgn && ld[15]) ld[31:16] = '1;
                end else begin
                    ld = w;
                end
                exp_q.push_back({dest, ld});
            end
        end
    endtask

    task automatic idle();
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    initial begin
        for (int i = 0; i < 16; i++) begin
            ram[i]    = 32'h8A3C_5E71 ^ (i * 32'h0101_0101);
            shadow[i] = 32'h8A3C_5E71 ^ (i * 32'h0101_0101);
        end
        repeat (3) @(negedge clk);
        #1;
        chk(wb_valid == 1'b0, "R12", "wb_valid in reset", {31'd0, wb_valid}, 32'd0);
        chk(mem_req == 1'b0, "R12", "mem_req idle", {31'd0, mem_req}, 32'd0);
        @(negedge clk); rst = 1'b0;
        #1;
        chk(wb_valid == 1'b0, "R12", "wb_valid after reset", {31'd0, wb_valid}, 32'd0);

        // R8: word stores, one via negative offset (R1)
        do_op(6'd34, 32'h0000_0010, 16'h0000, 32'hF0E1_D2C3, 6'd1, "R8");
        do_op(6'd34, 32'h0000_0024, 16'hFFFC, 32'h1234_5678, 6'd2, "R8");
        // R6: byte stores on every lane
        do_op(6'd32, 32'h0000_0030, 16'h0000, 32'h0000_00A5, 6'd3, "R6");
        do_op(6'd32, 32'h0000_0030, 16'h0001, 32'hFFFF_FF80, 6'd3, "R6");
        do_op(6'd32, 32'h0000_0031, 16'h0001, 32'h0000_0042, 6'd3, "R6");
        do_op(6'd32, 32'h0000_0034, 16'hFFFF, 32'h0000_00FF, 6'd3, "R6");
        // R7: halfword stores on both halves
        do_op(6'd33, 32'h0000_0008, 16'h0000, 32'h0000_8001, 6'd4, "R7");
        do_op(6'd33, 32'h0000_0008, 16'h0002, 32'hDEAD_7FFE, 6'd4, "R7");
        idle();
        // R2: byte loads signed/unsigned on each lane, back to back (R5)
        for (int k = 0; k < 4; k++) begin
            do_op(6'd0, 32'h0000_0030, 16'(k), 32'd0, 6'(10 + k), "R2");
            do_op(6'd4, 32'h0000_0030, 16'(k), 32'd0, 6'(20 + k), "R2");
        end
        // R3: halfword loads
        do_op(6'd1, 32'h0000_0008, 16'h0000, 32'd0, 6'd30, "R3");
        do_op(6'd5, 32'h0000_0008, 16'h0000, 32'd0, 6'd31, "R3");
        do_op(6'd1, 32'h0000_000A, 16'h0000, 32'd0, 6'd32, "R3");
        do_op(6'd5, 32'h0000_000C, 16'hFFFE, 32'd0, 6'd33, "R3");
        // R4: word loads
        do_op(6'd2, 32'h0000_0010, 16'h0000, 32'd0, 6'd40, "R4");
        do_op(6'd2, 32'h0000_0030, 16'hFFF0, 32'd0, 6'd41, "R4");
        do_op(6'd2, 32'h0000_003C, 16'h0000, 32'd0, 6'd42, "R4");
        // R9/R10: misaligned accesses trap, nothing reaches memory
        do_op(6'd1, 32'h0000_0008, 16'h0001, 32'd0, 6'd50, "R9");
        do_op(6'd5, 32'h0000_000B, 16'h0000, 32'd0, 6'd51, "R9");
        do_op(6'd2, 32'h0000_0010, 16'h0002, 32'd0, 6'd52, "R9");
        do_op(6'd33, 32'h0000_0010, 16'h0003, 32'h5555_5555, 6'd53, "R10");
        do_op(6'd34, 32'h0000_0010, 16'h0001, 32'h6666_6666, 6'd54, "R10");
        // R11: unknown codes do nothing
        do_op(6'd3, 32'h0000_0010, 16'h0000, 32'h7777_7777, 6'd55, "R11");
        do_op(6'd40, 32'h0000_0010, 16'h0000, 32'h7777_7777, 6'd56, "R11");
        do_op(6'd35, 32'h0000_0014, 16'h0000, 32'h7777_7777, 6'd57, "R11");
        // read back words that the trapped and ignored stores could have touched
        do_op(6'd2, 32'h0000_0010, 16'h0000, 32'd0, 6'd60, "R10");
        do_op(6'd2, 32'h0000_0014, 16'h0000, 32'd0, 6'd61, "R11");
        // R6 again after R9: byte stores stay legal at odd addresses
        do_op(6'd32, 32'h0000_0013, 16'h0000, 32'h0000_0099, 6'd62, "R6");
        do_op(6'd0, 32'h0000_0013, 16'h0000, 32'd0, 6'd63, "R2");
        idle();
        repeat (3) @(negedge clk);
        chk(exp_q.size() == 0, "R5", "pending writebacks", exp_q.size(), 32'd0);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule